// File: doc/BRIEF.md
# DMA Channel Trigger and Queue Unit

This unit gathers transfer requests for 64 regular DMA channels and 4 quick channels. It turns them into channel numbers placed in four event queues, which feed the downstream transfer engines. A regular channel fires from any of three sources: a software register write pulse, an external peripheral event, or the completion chain of another transfer. A quick channel fires when software writes the trigger word of its parameter set. Each triggered channel holds a pending bit until it is queued.

Each channel goes to the queue that a per-channel map selects. Queues are 16 entries deep, and the unit moves at most one channel into them per cycle. One output port with a valid/ready handshake presents the head of the winning queue. The winner is the non-empty queue with the best programmed priority. For debug, each queue records its peak occupancy and raises a sticky flag when its occupancy reaches a programmed threshold. The unit also keeps a missed-trigger error bit for each channel and a completion flag for each channel.

Top module: `dma_trig_queue`

## Requirements
- R1: After reset, ent_valid_o is 0 and every queue level, watermark, threshold flag, missed-trigger bit and completion flag is 0.
- R2: A one-cycle pulse on sw_trig_i[n], ext_evt_i[n] or chain_done_i[n] makes channel n pending. If its queue has room, channel n is queued on the second rising edge after the pulse. It appears on ent_ch_o, with ent_q_o equal to its 2-bit map field chan_qmap_i[2n+1:2n].
- R3: Quick channel k (ID 64+k) triggers only when qwr_valid_i is 1, qwr_chan_i is k and qwr_word_i is 7. A write to any other word index queues nothing.
- R4: At most one channel is queued per cycle. Among pending channels whose queue is not full, the lowest ID is queued first.
- R5: A trigger that arrives while its channel is still pending sets miss_o for that channel and is dropped, so the channel is queued only once. A one on miss_clr_i clears the bit.
- R6: Each queue is first-in first-out and holds 16 entries. A pending channel whose queue is full stays pending and does not block channels that map to other queues.
- R7: When several queues are non-empty, the output takes the head of the queue whose 3-bit priority field in q_prio_i has the smallest value. On equal values, the lower queue index wins.
- R8: q_wmark_o holds the highest level the queue has reached since reset or since the last one on its wm_clr_i bit, which writes it to zero.
- R9: q_thr_o[q] is set once the level of queue q is at least its nonzero 5-bit threshold. It stays set until a one on thr_clr_i[q]. A threshold of 0 never sets it.
- R10: A pulse on xfer_done_i sets done_o for channel xfer_done_ch_i. done_clr_i clears it.
- R11: While ent_valid_o is 1 and ent_ready_i is 0, ent_valid_o stays 1 and no entry leaves any queue. An entry leaves a queue only in a cycle with both signals high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_trig_i | input | 64 | Software register-write trigger pulses, one per channel |
| ext_evt_i | input | 64 | External event trigger pulses |
| chain_done_i | input | 64 | Chained-completion trigger pulses |
| qwr_valid_i | input | 1 | Quick channel parameter write strobe |
| qwr_chan_i | input | 2 | Quick channel addressed by the write |
| qwr_word_i | input | 3 | Word index within the parameter set being written |
| chan_qmap_i | input | 136 | 2-bit target queue for each of the 68 channel IDs |
| q_prio_i | input | 12 | 3-bit priority per queue, 0 is highest |
| q_thresh_i | input | 20 | 5-bit occupancy threshold per queue |
| wm_clr_i | input | 4 | Watermark clear per queue |
| thr_clr_i | input | 4 | Threshold flag clear per queue |
| miss_clr_i | input | 68 | Missed-trigger bit clear per channel |
| xfer_done_i | input | 1 | Transfer completion strobe |
| xfer_done_ch_i | input | 7 | Channel that completed |
| done_clr_i | input | 68 | Completion flag clear per channel |
| ent_valid_o | output | 1 | Queue entry available |
| ent_ready_i | input | 1 | Downstream accepts the entry |
| ent_ch_o | output | 7 | Channel ID of the entry |
| ent_q_o | output | 2 | Queue the entry comes from |
| q_level_o | output | 20 | 5-bit occupancy per queue |
| q_wmark_o | output | 20 | 5-bit peak occupancy per queue |
| q_thr_o | output | 4 | Sticky threshold-reached flag per queue |
| miss_o | output | 68 | Missed-trigger error bit per channel |
| done_o | output | 68 | Completion flag per channel |

## Verification
The hardest case to reach is a full queue that holds back one of its own channels while a channel mapped elsewhere passes it. The bench maps seventeen channels and one outsider to two queues and fires them all in one cycle. It stalls the output and waits until one queue shows level 16 and the other level 1. It then pops a single entry and confirms that the held-back channel enters the freed slot. The missed-trigger path needs a trigger in the one cycle a channel is still pending. The bench holds a trigger high across two edges to land there.

// File: rtl/dtq_pkg.sv
package dtq_pkg;
    localparam int NUM_CH    = 64;
    localparam int NUM_QCH   = 4;
    localparam int NUM_Q     = 4;
    localparam int Q_DEPTH   = 16;
    localparam int PRIO_W    = 3;
    localparam int WORD_W    = 3;
    localparam int TRIG_WORD = 7;
    localparam int NUM_ID    = NUM_CH + NUM_QCH;
    localparam int ID_W      = $clog2(NUM_ID);
    localparam int QSEL_W    = $clog2(NUM_Q);
    localparam int QCH_W     = $clog2(NUM_QCH);
    localparam int CNT_W     = $clog2(Q_DEPTH + 1);

    typedef logic [ID_W-1:0]   chan_id_t;
    typedef logic [QSEL_W-1:0] qsel_t;
    typedef logic [CNT_W-1:0]  level_t;

    typedef struct packed {
        logic     valid;
        chan_id_t ch;
        qsel_t    q;
    } enq_req_t;

    function automatic level_t level_max(input level_t a, input level_t b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/dtq_pend.sv
module dtq_pend
    import dtq_pkg::*;
#(
    parameter int N  = NUM_ID,
    parameter int QW = QSEL_W,
    parameter int NQ = NUM_Q
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N-1:0]    trig,
    input  logic [N*QW-1:0] qmap,
    input  logic [NQ-1:0]   qfull,
    input  logic [N-1:0]    miss_clr,
    output logic [N-1:0]    pend,
    output logic [N-1:0]    miss,
    output logic [N-1:0]    pick,
    output enq_req_t        enq
);
    logic [N-1:0] elig;
    int unsigned  sel;

    always_comb begin
        for (int i = 0; i < N; i++)
            elig[i] = pend[i] & ~qfull[qmap[i*QW +: QW]];
        sel = 0;
        for (int i = N - 1; i >= 0; i--)
            if (elig[i]) sel = i;
        pick = '0;
        if (|elig) pick[sel] = 1'b1;
        enq.valid = |elig;
        enq.ch    = chan_id_t'(sel);
        enq.q     = qsel_t'(qmap[sel*QW +: QW]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= '0;
            miss <= '0;
        end else begin
            pend <= (pend & ~pick) | (trig & ~pend);
            miss <= (miss & ~miss_clr) | (trig & pend);
        end
    end
endmodule

// File: rtl/dtq_fifo.sv
module dtq_fifo #(
    parameter int W     = 7,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic [CW-1:0] level,
    output logic         full,
    output logic         empty
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          do_push, do_pop;

    assign full    = (level == CW'(DEPTH));
    assign empty   = (level == '0);
    assign do_push = push & ~full;
    assign do_pop  = pop & ~empty;
    assign dout    = mem[rp];

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else begin
            if (do_push) begin
                mem[wp] <= din;
                wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            end
            if (do_pop)
                rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            if (do_push && !do_pop)
                level <= level + 1'b1;
            else if (do_pop && !do_push)
                level <= level - 1'b1;
        end
    end
endmodule

// File: rtl/dtq_arb.sv
module dtq_arb #(
    parameter int NQ = 4,
    parameter int PW = 3,
    localparam int GW = $clog2(NQ)
) (
    input  logic [NQ-1:0]    nonempty,
    input  logic [NQ*PW-1:0] prio,
    output logic [GW-1:0]    grant,
    output logic             any
);
    logic [PW-1:0] best;

    always_comb begin
        any   = 1'b0;
        grant = '0;
        best  = '1;
        for (int q = 0; q < NQ; q++) begin
            if (nonempty[q] && (!any || prio[q*PW +: PW] < best)) begin
                any   = 1'b1;
                grant = GW'(q);
                best  = prio[q*PW +: PW];
            end
        end
    end
endmodule

// File: rtl/dma_trig_queue.sv
module dma_trig_queue
    import dtq_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NUM_CH-1:0]        sw_trig_i,
    input  logic [NUM_CH-1:0]        ext_evt_i,
    input  logic [NUM_CH-1:0]        chain_done_i,
    input  logic                     qwr_valid_i,
    input  logic [QCH_W-1:0]         qwr_chan_i,
    input  logic [WORD_W-1:0]        qwr_word_i,
    input  logic [NUM_ID*QSEL_W-1:0] chan_qmap_i,
    input  logic [NUM_Q*PRIO_W-1:0]  q_prio_i,
    input  logic [NUM_Q*CNT_W-1:0]   q_thresh_i,
    input  logic [NUM_Q-1:0]         wm_clr_i,
    input  logic [NUM_Q-1:0]         thr_clr_i,
    input  logic [NUM_ID-1:0]        miss_clr_i,
    input  logic                     xfer_done_i,
    input  logic [ID_W-1:0]          xfer_done_ch_i,
    input  logic [NUM_ID-1:0]        done_clr_i,
    output logic                     ent_valid_o,
    input  logic                     ent_ready_i,
    output logic [ID_W-1:0]          ent_ch_o,
    output logic [QSEL_W-1:0]        ent_q_o,
    output logic [NUM_Q*CNT_W-1:0]   q_level_o,
    output logic [NUM_Q*CNT_W-1:0]   q_wmark_o,
    output logic [NUM_Q-1:0]         q_thr_o,
    output logic [NUM_ID-1:0]        miss_o,
    output logic [NUM_ID-1:0]        done_o
);
    logic [NUM_ID-1:0] trig, pend, pick;
    logic [NUM_QCH-1:0] quick_hit;
    logic [NUM_Q-1:0]  qfull, qempty, qpop;
    chan_id_t          qhead [NUM_Q];
    qsel_t             grant;
    enq_req_t          enq;

    // quick channels fire only on the designated parameter word
    always_comb begin
        for (int k = 0; k < NUM_QCH; k++)
            quick_hit[k] = qwr_valid_i && (qwr_chan_i == QCH_W'(k))
                           && (qwr_word_i == WORD_W'(TRIG_WORD));
    end

    assign trig = {quick_hit, sw_trig_i | ext_evt_i | chain_done_i};

    dtq_pend #(.N(NUM_ID), .QW(QSEL_W), .NQ(NUM_Q)) u_pend (
        .clk      (clk),
        .rst      (rst),
        .trig     (trig),
        .qmap     (chan_qmap_i),
        .qfull    (qfull),
        .miss_clr (miss_clr_i),
        .pend     (pend),
        .miss     (miss_o),
        .pick     (pick),
        .enq      (enq)
    );

    generate
        for (genvar q = 0; q < NUM_Q; q++) begin : g_queue
            level_t lvl, wm_r;
            logic   thr_r;
            level_t thr_lim;

            assign thr_lim = q_thresh_i[q*CNT_W +: CNT_W];

            dtq_fifo #(.W(ID_W), .DEPTH(Q_DEPTH)) u_fifo (
                .clk   (clk),
                .rst   (rst),
                .push  (enq.valid && enq.q == qsel_t'(q)),
                .din   (enq.ch),
                .pop   (qpop[q]),
                .dout  (qhead[q]),
                .level (lvl),
                .full  (qfull[q]),
                .empty (qempty[q])
            );

            always_ff @(posedge clk) begin
                if (rst) begin
                    wm_r  <= '0;
                    thr_r <= 1'b0;
                end else begin
                    wm_r  <= wm_clr_i[q] ? '0 : level_max(wm_r, lvl);
                    thr_r <= (thr_r & ~thr_clr_i[q])
                             | ((thr_lim != '0) && (lvl >= thr_lim));
                end
            end

            assign qpop[q] = ent_ready_i && ent_valid_o && (grant == qsel_t'(q));
            assign q_level_o[q*CNT_W +: CNT_W] = lvl;
            assign q_wmark_o[q*CNT_W +: CNT_W] = wm_r;
            assign q_thr_o[q] = thr_r;
        end
    endgenerate

    dtq_arb #(.NQ(NUM_Q), .PW(PRIO_W)) u_arb (
        .nonempty (~qempty),
        .prio     (q_prio_i),
        .grant    (grant),
        .any      (ent_valid_o)
    );

    assign ent_ch_o = qhead[grant];
    assign ent_q_o  = grant;

    always_ff @(posedge clk) begin
        if (rst) begin
            done_o <= '0;
        end else begin
            for (int i = 0; i < NUM_ID; i++)
                done_o[i] <= (done_o[i] & ~done_clr_i[i])
                             | (xfer_done_i && xfer_done_ch_i == ID_W'(i));
        end
    end
endmodule

// File: rtl/dtq_chk.sv
module dtq_chk
    import dtq_pkg::*;
(
    input logic                   clk,
    input logic                   rst,
    input logic                   ent_valid_o,
    input logic                   ent_ready_i,
    input logic [NUM_ID-1:0]      trig,
    input logic [NUM_ID-1:0]      pend,
    input logic [NUM_ID-1:0]      pick,
    input logic [NUM_ID-1:0]      miss_o,
    input logic [NUM_Q*CNT_W-1:0] q_level_o,
    input logic [NUM_Q*CNT_W-1:0] q_wmark_o,
    input logic [NUM_Q-1:0]       q_thr_o,
    input logic [NUM_Q-1:0]       wm_clr_i,
    input logic [NUM_Q-1:0]       thr_clr_i
);
    p_valid_hold_r11: assert property (@(posedge clk) disable iff (rst)
        ent_valid_o && !ent_ready_i |=> ent_valid_o);

    p_one_enq_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(pick));

    p_miss_set_r5: assert property (@(posedge clk) disable iff (rst)
        |(pend & trig) |=> ((miss_o & $past(pend & trig)) == $past(pend & trig)));

    generate
        for (genvar q = 0; q < NUM_Q; q++) begin : g_qchk
            p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
                q_level_o[q*CNT_W +: CNT_W] <= CNT_W'(Q_DEPTH));

            p_wm_track_r8: assert property (@(posedge clk) disable iff (rst)
                !$past(wm_clr_i[q]) |->
                q_wmark_o[q*CNT_W +: CNT_W] >= $past(q_level_o[q*CNT_W +: CNT_W]));

            p_thr_sticky_r9: assert property (@(posedge clk) disable iff (rst)
                q_thr_o[q] && !thr_clr_i[q] |=> q_thr_o[q]);
        end
    endgenerate
endmodule

bind dma_trig_queue dtq_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .ent_valid_o (ent_valid_o),
    .ent_ready_i (ent_ready_i),
    .trig        (trig),
    .pend        (pend),
    .pick        (pick),
    .miss_o      (miss_o),
    .q_level_o   (q_level_o),
    .q_wmark_o   (q_wmark_o),
    .q_thr_o     (q_thr_o),
    .wm_clr_i    (wm_clr_i),
    .thr_clr_i   (thr_clr_i)
);

// File: tb/sim_dma_trig_queue.sv
`timescale 1ns/1ps
module sim_dma_trig_queue;
    import dtq_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NUM_CH-1:0] sw_trig = '0, ext_evt = '0, chain_done = '0;
    logic qwr_valid = 1'b0;
    logic [QCH_W-1:0] qwr_chan = '0;
    logic [WORD_W-1:0] qwr_word = '0;
    logic [NUM_ID*QSEL_W-1:0] qmap = '0;
    logic [NUM_Q*PRIO_W-1:0] prio = '0;
    logic [NUM_Q*CNT_W-1:0] thresh = '0;
    logic [NUM_Q-1:0] wm_clr = '0, thr_clr = '0;
    logic [NUM_ID-1:0] miss_clr = '0, done_clr = '0;
    logic xfer_done = 1'b0;
    logic [ID_W-1:0] xfer_done_ch = '0;
    logic ent_valid, ent_ready = 1'b0;
    logic [ID_W-1:0] ent_ch;
    logic [QSEL_W-1:0] ent_q;
    logic [NUM_Q*CNT_W-1:0] level, wmark;
    logic [NUM_Q-1:0] thr;
    logic [NUM_ID-1:0] miss, done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    dma_trig_queue u0 (
        .clk(clk), .rst(rst),
        .sw_trig_i(sw_trig), .ext_evt_i(ext_evt), .chain_done_i(chain_done),
        .qwr_valid_i(qwr_valid), .qwr_chan_i(qwr_chan), .qwr_word_i(qwr_word),
        .chan_qmap_i(qmap), .q_prio_i(prio), .q_thresh_i(thresh),
        .wm_clr_i(wm_clr), .thr_clr_i(thr_clr), .miss_clr_i(miss_clr),
        .xfer_done_i(xfer_done), .xfer_done_ch_i(xfer_done_ch), .done_clr_i(done_clr),
        .ent_valid_o(ent_valid), .ent_ready_i(ent_ready),
        .ent_ch_o(ent_ch), .ent_q_o(ent_q),
        .q_level_o(level), .q_wmark_o(wmark), .q_thr_o(thr),
        .miss_o(miss), .done_o(done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int lvl(input int q);
        return int'(level[q*CNT_W +: CNT_W]);
    endfunction

    task automatic set_map(input int ch, input int q);
        qmap[ch*QSEL_W +: QSEL_W] = QSEL_W'(q);
    endtask

    task automatic pop_expect(input int ch, input int q, input string req);
        check(ent_valid == 1'b1, req, int'(ent_valid), 1);
        check(int'(ent_ch) == ch, req, int'(ent_ch), ch);
        check(int'(ent_q) == q, req, int'(ent_q), q);
        ent_ready = 1'b1;
        cyc(1);
        ent_ready = 1'b0;
    endtask

    task automatic t_reset();
        check(ent_valid == 1'b0, "R1 valid", int'(ent_valid), 0);
        check(level == '0, "R1 level", int'(|level), 0);
        check(wmark == '0, "R1 wmark", int'(|wmark), 0);
        check(thr == '0, "R1 thr", int'(|thr), 0);
        check(miss == '0 && done == '0, "R1 flags", int'(|{miss, done}), 0);
    endtask

    task automatic t_sources();
        sw_trig[5] = 1'b1;
        cyc(1);
        sw_trig[5] = 1'b0;
        check(ent_valid == 1'b0, "R2 latency", int'(ent_valid), 0);
        cyc(1);
        pop_expect(5, 0, "R2 sw");
        ext_evt[9] = 1'b1;
        cyc(1);
        ext_evt[9] = 1'b0;
        cyc(2);
        pop_expect(9, 0, "R2 ext");
        set_map(12, 3);
        chain_done[12] = 1'b1;
        cyc(1);
        chain_done[12] = 1'b0;
        cyc(2);
        pop_expect(12, 3, "R2 chain");
    endtask

    task automatic t_quick();
        qwr_valid = 1'b1; qwr_chan = 2'd1; qwr_word = 3'd2;
        cyc(1);
        qwr_valid = 1'b0;
        cyc(3);
        check(ent_valid == 1'b0, "R3 other word", int'(ent_valid), 0);
        qwr_valid = 1'b1; qwr_chan = 2'd2; qwr_word = 3'd7;
        cyc(1);
        qwr_valid = 1'b0;
        cyc(2);
        pop_expect(NUM_CH + 2, 0, "R3 trigger word");
    endtask

    task automatic t_order();
        sw_trig[40] = 1'b1; ext_evt[3] = 1'b1; chain_done[17] = 1'b1;
        cyc(1);
        sw_trig = '0; ext_evt = '0; chain_done = '0;
        cyc(4);
        check(lvl(0) == 3, "R4 level", lvl(0), 3);
        pop_expect(3, 0, "R4 first");
        pop_expect(17, 0, "R4 second");
        pop_expect(40, 0, "R4 third");
    endtask

    task automatic t_miss();
        sw_trig[8] = 1'b1;
        cyc(2);
        sw_trig[8] = 1'b0;
        cyc(3);
        check(miss[8] == 1'b1, "R5 miss set", int'(miss[8]), 1);
        check(lvl(0) == 1, "R5 single entry", lvl(0), 1);
        pop_expect(8, 0, "R5 entry");
        check(ent_valid == 1'b0, "R5 no duplicate", int'(ent_valid), 0);
        miss_clr[8] = 1'b1;
        cyc(1);
        miss_clr[8] = 1'b0;
        check(miss[8] == 1'b0, "R5 miss clear", int'(miss[8]), 0);
    endtask

    task automatic t_full();
        for (int c = 0; c <= 16; c++) set_map(c, 1);
        set_map(20, 2);
        prio = {3'd7, 3'd5, 3'd0, 3'd7};
        thresh = {5'd0, 5'd2, 5'd12, 5'd0};
        for (int c = 0; c <= 16; c++) sw_trig[c] = 1'b1;
        sw_trig[20] = 1'b1;
        cyc(1);
        sw_trig = '0;
        cyc(25);
        check(lvl(1) == 16, "R6 queue full", lvl(1), 16);
        check(lvl(2) == 1, "R6 bypass", lvl(2), 1);
        check(int'(wmark[1*CNT_W +: CNT_W]) == 16, "R8 peak", int'(wmark[1*CNT_W +: CNT_W]), 16);
        check(thr[1] == 1'b1, "R9 reached", int'(thr[1]), 1);
        check(thr[2] == 1'b0, "R9 below", int'(thr[2]), 0);
        check(thr[0] == 1'b0, "R9 zero disables", int'(thr[0]), 0);
        pop_expect(0, 1, "R6 head");
        cyc(3);
        check(lvl(1) == 16, "R6 held channel enters", lvl(1), 16);
        for (int c = 1; c <= 16; c++) pop_expect(c, 1, "R6 fifo order");
        pop_expect(20, 2, "R7 lower priority last");
        cyc(2);
        check(thr[1] == 1'b1, "R9 sticky", int'(thr[1]), 1);
        wm_clr[1] = 1'b1; thr_clr[1] = 1'b1;
        cyc(1);
        wm_clr[1] = 1'b0; thr_clr[1] = 1'b0;
        cyc(2);
        check(int'(wmark[1*CNT_W +: CNT_W]) == 0, "R8 clear", int'(wmark[1*CNT_W +: CNT_W]), 0);
        check(thr[1] == 1'b0, "R9 clear", int'(thr[1]), 0);
        thresh = '0;
    endtask

    task automatic t_arb();
        set_map(30, 0); set_map(31, 1); set_map(32, 2); set_map(33, 3);
        prio = {3'd6, 3'd2, 3'd2, 3'd4};
        ext_evt[33:30] = 4'hF;
        cyc(1);
        ext_evt = '0;
        cyc(8);
        check(ent_valid == 1'b1, "R11 valid held", int'(ent_valid), 1);
        check(lvl(0) + lvl(1) + lvl(2) + lvl(3) == 4, "R11 no loss", lvl(0) + lvl(1) + lvl(2) + lvl(3), 4);
        pop_expect(31, 1, "R7 best priority tie");
        pop_expect(32, 2, "R7 second");
        pop_expect(30, 0, "R7 third");
        pop_expect(33, 3, "R7 last");
        check(ent_valid == 1'b0, "R11 drained", int'(ent_valid), 0);
    endtask

    task automatic t_done();
        xfer_done = 1'b1; xfer_done_ch = 7'd50;
        cyc(1);
        xfer_done = 1'b0;
        check(done[50] == 1'b1, "R10 set", int'(done[50]), 1);
        check(done[49] == 1'b0, "R10 other", int'(done[49]), 0);
        done_clr[50] = 1'b1;
        cyc(1);
        done_clr[50] = 1'b0;
        check(done[50] == 1'b0, "R10 clear", int'(done[50]), 0);
    endtask

    initial begin
        cyc(3);
        rst = 1'b0;
        cyc(1);
        t_reset();
        t_sources();
        t_quick();
        t_order();
        t_miss();
        t_full();
        t_arb();
        t_done();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule